// File: doc/BRIEF.md
# Level-Aware TLB Tag Entry

This block is one slot of a translation lookaside buffer for a three-level paged address space. A 32-bit virtual address is split into three index fields and a 12-bit page offset. Each slot stores the tag and payload of one cached translation. The tag is a context number plus the three index fields. The payload is the descriptor type, access code, supervisor flag, modified, referenced and cacheable flags, and a 24-bit physical page number. The slot also keeps a two-bit level that records how deep in the table the mapping was found. The level decides how many index fields take part in a compare, so one slot can map a 4 KB page, a segment, a region or a whole context.

The slot answers two kinds of question in the same cycle they are asked, so neither port has a handshake or back-pressure. The lookup port takes a virtual address and context. It returns a hit flag and the merged physical address. The flush/probe port takes a typed flush or probe address and a context. It says whether the slot falls inside that operation. A flush that hits drops the valid bit at the next edge. A probe only reports. The slot can be loaded, invalidated, have its modified bit set, and be read out field by field. The surrounding array, the table walker and the permission checks live outside the block.

Top module: `tlb_tag_entry`

## Requirements
- R1: While reset is held and after it is released, the slot is invalid, every stored field reads zero, and neither `lk_hit` nor `fp_hit` is asserted.
- R2: When `ld_en` is high at a rising edge, every field is stored from the load inputs and valid becomes 1. The three index fields come from `ld_va` bits 31:24, 23:18 and 17:12. The type code is stored unchanged (00 invalid, 01 table pointer, 10 translation, 11 reserved). `rd_su` is 1 exactly when the stored access code is 6 or 7.
- R3: `lk_hit` is combinational. It is 1 only when the slot is valid, `lk_ctx` equals the stored context, and the index fields picked by the stored level match `lk_va`. Level 00 compares bits 31:12, level 01 compares bits 31:18, level 10 compares bits 31:24, and level 11 compares no index bits.
- R4: On a hit, `lk_pa` (36 bits) is the page number followed by the untranslated low bits of `lk_va`. Level 00 gives {ppn, va[11:0]}, level 01 gives {ppn[23:6], va[17:0]}, level 10 gives {ppn[23:12], va[23:0]}, and level 11 gives {ppn[23:20], va[31:0]}.
- R5: `fp_hit` is combinational and needs `fp_en` and a valid slot. The type is taken from `fp_addr` bits 10:8, and the index fields from bits 31:24, 23:18 and 17:12.
  - Type 000 needs a context match, level 00 and bits 31:12 equal.
  - Type 001 needs a context match, level 00 or 01, and bits 31:18 equal.
  - Type 010 needs a context match, any level but 11, and bits 31:24 equal.
  - Type 011 needs only a context match.
  - Type 100 hits any valid slot.
  - Bits 11 and 7:0 of `fp_addr` are ignored.
- R6: A hit with `fp_flush` = 1 clears valid at the next edge. A probe (`fp_flush` = 0) changes no state. While `fp_hit` is high, `fp_lvl` shows the stored level.
- R7: `inv_en` clears valid at the next edge. A load in the same cycle wins over both invalidate and a flush hit.
- R8: `set_mod_en` sets the modified bit at the next edge when the slot is valid and no load is present, and leaves every other field unchanged. It has no effect on an invalid slot.
- R9: Flush/probe types 101, 110 and 111 never hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Load strobe |
| ld_et | input | 2 | Descriptor type to store |
| ld_acc | input | 3 | Access code to store |
| ld_mod | input | 1 | Modified flag to store |
| ld_ref | input | 1 | Referenced flag to store |
| ld_lvl | input | 2 | Mapping level to store |
| ld_va | input | 32 | Virtual address supplying the index tag |
| ld_ctx | input | 8 | Context number to store |
| ld_ppn | input | 24 | Physical page number to store |
| ld_cach | input | 1 | Cacheable flag to store |
| inv_en | input | 1 | Invalidate strobe |
| set_mod_en | input | 1 | Set-modified strobe |
| lk_va | input | 32 | Lookup virtual address |
| lk_ctx | input | 8 | Lookup context |
| lk_hit | output | 1 | Lookup hit |
| lk_pa | output | 36 | Merged physical address |
| fp_en | input | 1 | Flush/probe request |
| fp_flush | input | 1 | 1 flush, 0 probe |
| fp_addr | input | 32 | Flush/probe address with type in bits 10:8 |
| fp_ctx | input | 8 | Flush/probe context |
| fp_hit | output | 1 | Slot lies within the flush/probe |
| fp_lvl | output | 2 | Stored level for probe reply |
| rd_valid | output | 1 | Stored valid bit |
| rd_et | output | 2 | Stored descriptor type |
| rd_acc | output | 3 | Stored access code |
| rd_su | output | 1 | Stored supervisor flag |
| rd_mod | output | 1 | Stored modified flag |
| rd_ref | output | 1 | Stored referenced flag |
| rd_lvl | output | 2 | Stored level |
| rd_vtag | output | 20 | Stored index fields, first index in the top bits |
| rd_ctx | output | 8 | Stored context |
| rd_ppn | output | 24 | Stored page number |
| rd_cach | output | 1 | Stored cacheable flag |

## Verification
A wrong stored level or index tag shows at once on the next lookup or probe near the tag. It appears as a missing or extra hit, or as a physical address whose split point has moved. A valid bit that survives a flush or invalidate shows up one cycle later as a stale hit. A valid bit lost during a probe shows up one cycle later as a missing hit. The bench compares every output in every cycle against a model driven by the same strobes, so any such error is caught within one cycle of the fault. The lookup and flush/probe patterns are drawn close to the stored tag so that single-field mismatches come up often.

// File: rtl/tlbe_pkg.sv
package tlbe_pkg;
  localparam logic [1:0] LV_PAGE   = 2'b00;
  localparam logic [1:0] LV_SEG    = 2'b01;
  localparam logic [1:0] LV_REGION = 2'b10;
  localparam logic [1:0] LV_CTX    = 2'b11;

  localparam logic [2:0] FP_PAGE   = 3'b000;
  localparam logic [2:0] FP_SEG    = 3'b001;
  localparam logic [2:0] FP_REGION = 3'b010;
  localparam logic [2:0] FP_CTX    = 3'b011;
  localparam logic [2:0] FP_ALL    = 3'b100;

  localparam int FP_TY_LSB = 8;
  localparam int FP_TY_W   = 3;

  function automatic logic acc_is_super(input logic [2:0] acc);
    return acc >= 3'd6;
  endfunction
endpackage

// File: rtl/tlbe_store.sv
module tlbe_store #(
  parameter int CTX_W = 8,
  parameter int I1_W  = 8,
  parameter int I2_W  = 6,
  parameter int I3_W  = 6,
  parameter int PPN_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_en,
  input  logic [1:0]       ld_et,
  input  logic [2:0]       ld_acc,
  input  logic             ld_mod,
  input  logic             ld_ref,
  input  logic [1:0]       ld_lvl,
  input  logic [I1_W-1:0]  ld_i1,
  input  logic [I2_W-1:0]  ld_i2,
  input  logic [I3_W-1:0]  ld_i3,
  input  logic [CTX_W-1:0] ld_ctx,
  input  logic [PPN_W-1:0] ld_ppn,
  input  logic             ld_cach,
  input  logic             clr_en,
  input  logic             set_mod_en,
  output logic             q_valid,
  output logic [1:0]       q_et,
  output logic [2:0]       q_acc,
  output logic             q_su,
  output logic             q_mod,
  output logic             q_ref,
  output logic [1:0]       q_lvl,
  output logic [I1_W-1:0]  q_i1,
  output logic [I2_W-1:0]  q_i2,
  output logic [I3_W-1:0]  q_i3,
  output logic [CTX_W-1:0] q_ctx,
  output logic [PPN_W-1:0] q_ppn,
  output logic             q_cach
);
  import tlbe_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_et    <= '0;
      q_acc   <= '0;
      q_su    <= 1'b0;
      q_mod   <= 1'b0;
      q_ref   <= 1'b0;
      q_lvl   <= '0;
      q_i1    <= '0;
      q_i2    <= '0;
      q_i3    <= '0;
      q_ctx   <= '0;
      q_ppn   <= '0;
      q_cach  <= 1'b0;
    end else if (ld_en) begin
      q_valid <= 1'b1;
      q_et    <= ld_et;
      q_acc   <= ld_acc;
      q_su    <= acc_is_super(ld_acc);
      q_mod   <= ld_mod;
      q_ref   <= ld_ref;
      q_lvl   <= ld_lvl;
      q_i1    <= ld_i1;
      q_i2    <= ld_i2;
      q_i3    <= ld_i3;
      q_ctx   <= ld_ctx;
      q_ppn   <= ld_ppn;
      q_cach  <= ld_cach;
    end else begin
      if (clr_en) q_valid <= 1'b0;
      if (set_mod_en && q_valid) q_mod <= 1'b1;
    end
  end

  AST_LOAD_SETS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> q_valid); // R2
  AST_SU_FOLLOWS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
    q_su == (q_acc >= 3'd6)); // R2
  AST_CLEAR_DROPS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !ld_en) |=> !q_valid); // R7
  AST_MOD_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_mod_en && q_valid && !ld_en) |=> q_mod); // R8
  AST_SET_MOD_KEEPS_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_en |=> ($stable(q_ppn) && $stable(q_ctx) && $stable(q_lvl))); // R8
  AST_INVALID_IGNORES_SET_MOD: assert property (@(posedge clk) disable iff (!rst_n)
    (!q_valid && !ld_en) |=> $stable(q_mod)); // R8
endmodule

// File: rtl/tlbe_lookup.sv
module tlbe_lookup #(
  parameter int CTX_W = 8,
  parameter int I1_W  = 8,
  parameter int I2_W  = 6,
  parameter int I3_W  = 6,
  parameter int OFF_W = 12,
  parameter int PPN_W = 24,
  localparam int VA_W = I1_W + I2_W + I3_W + OFF_W,
  localparam int PA_W = PPN_W + OFF_W
) (
  input  logic [VA_W-1:0]  va,
  input  logic [CTX_W-1:0] ctx,
  input  logic             q_valid,
  input  logic [1:0]       q_lvl,
  input  logic [I1_W-1:0]  q_i1,
  input  logic [I2_W-1:0]  q_i2,
  input  logic [I3_W-1:0]  q_i3,
  input  logic [CTX_W-1:0] q_ctx,
  input  logic [PPN_W-1:0] q_ppn,
  output logic             hit,
  output logic [PA_W-1:0]  pa
);
  import tlbe_pkg::*;

  localparam int S3 = OFF_W;
  localparam int S2 = OFF_W + I3_W;
  localparam int S1 = OFF_W + I3_W + I2_W;

  // low-bit masks taken from the virtual address, one per level
  localparam logic [PA_W-1:0] M_PAGE   = {{(PA_W-S3){1'b0}}, {S3{1'b1}}};
  localparam logic [PA_W-1:0] M_SEG    = {{(PA_W-S2){1'b0}}, {S2{1'b1}}};
  localparam logic [PA_W-1:0] M_REGION = {{(PA_W-S1){1'b0}}, {S1{1'b1}}};
  localparam logic [PA_W-1:0] M_CTX    = {{(PA_W-VA_W){1'b0}}, {VA_W{1'b1}}};

  logic eq1, eq2, eq3, idx_ok;
  logic [PA_W-1:0] mask, hi_part, lo_part;

  always_comb begin
    eq1 = (va[VA_W-1 -: I1_W] == q_i1);
    eq2 = (va[S1-1 -: I2_W] == q_i2);
    eq3 = (va[S2-1 -: I3_W] == q_i3);
    unique case (q_lvl)
      LV_PAGE:   begin idx_ok = eq1 & eq2 & eq3; mask = M_PAGE;   end
      LV_SEG:    begin idx_ok = eq1 & eq2;       mask = M_SEG;    end
      LV_REGION: begin idx_ok = eq1;             mask = M_REGION; end
      default:   begin idx_ok = 1'b1;            mask = M_CTX;    end
    endcase
    hit     = q_valid & (ctx == q_ctx) & idx_ok;
    hi_part = {q_ppn, {OFF_W{1'b0}}};
    lo_part = {{(PA_W-VA_W){1'b0}}, va};
    pa      = (hi_part & ~mask) | (lo_part & mask);
  end
endmodule

// File: rtl/tlbe_fpmatch.sv
module tlbe_fpmatch #(
  parameter int CTX_W = 8,
  parameter int I1_W  = 8,
  parameter int I2_W  = 6,
  parameter int I3_W  = 6,
  parameter int OFF_W = 12,
  localparam int VA_W = I1_W + I2_W + I3_W + OFF_W
) (
  input  logic             fp_en,
  input  logic [VA_W-1:0]  fp_addr,
  input  logic [CTX_W-1:0] fp_ctx,
  input  logic             q_valid,
  input  logic [1:0]       q_lvl,
  input  logic [I1_W-1:0]  q_i1,
  input  logic [I2_W-1:0]  q_i2,
  input  logic [I3_W-1:0]  q_i3,
  input  logic [CTX_W-1:0] q_ctx,
  output logic             hit
);
  import tlbe_pkg::*;

  localparam int S2 = OFF_W + I3_W;
  localparam int S1 = OFF_W + I3_W + I2_W;
  localparam int TY_TOP = FP_TY_LSB + FP_TY_W;

  logic [FP_TY_W-1:0] ty;
  logic e1, e2, e3, cx, m;

  // the flag bit between the type field and the index fields is don't-care
  logic unused_bits;
  assign unused_bits = ^{fp_addr[OFF_W-1:TY_TOP], fp_addr[FP_TY_LSB-1:0]};

  always_comb begin
    ty = fp_addr[TY_TOP-1:FP_TY_LSB];
    e1 = (fp_addr[VA_W-1 -: I1_W] == q_i1);
    e2 = (fp_addr[S1-1 -: I2_W] == q_i2);
    e3 = (fp_addr[S2-1 -: I3_W] == q_i3);
    cx = (fp_ctx == q_ctx);
    case (ty)
      FP_PAGE:   m = cx & (q_lvl == LV_PAGE) & e1 & e2 & e3;
      FP_SEG:    m = cx & ((q_lvl == LV_PAGE) | (q_lvl == LV_SEG)) & e1 & e2;
      FP_REGION: m = cx & (q_lvl != LV_CTX) & e1;
      FP_CTX:    m = cx;
      FP_ALL:    m = 1'b1;
      default:   m = 1'b0;
    endcase
    hit = fp_en & q_valid & m;
  end
endmodule

// File: rtl/tlb_tag_entry.sv
module tlb_tag_entry #(
  parameter int CTX_W = 8,
  parameter int I1_W  = 8,
  parameter int I2_W  = 6,
  parameter int I3_W  = 6,
  parameter int OFF_W = 12,
  parameter int PPN_W = 24,
  localparam int VA_W  = I1_W + I2_W + I3_W + OFF_W,
  localparam int PA_W  = PPN_W + OFF_W,
  localparam int TAG_W = I1_W + I2_W + I3_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_en,
  input  logic [1:0]       ld_et,
  input  logic [2:0]       ld_acc,
  input  logic             ld_mod,
  input  logic             ld_ref,
  input  logic [1:0]       ld_lvl,
  input  logic [VA_W-1:0]  ld_va,
  input  logic [CTX_W-1:0] ld_ctx,
  input  logic [PPN_W-1:0] ld_ppn,
  input  logic             ld_cach,
  input  logic             inv_en,
  input  logic             set_mod_en,
  input  logic [VA_W-1:0]  lk_va,
  input  logic [CTX_W-1:0] lk_ctx,
  output logic             lk_hit,
  output logic [PA_W-1:0]  lk_pa,
  input  logic             fp_en,
  input  logic             fp_flush,
  input  logic [VA_W-1:0]  fp_addr,
  input  logic [CTX_W-1:0] fp_ctx,
  output logic             fp_hit,
  output logic [1:0]       fp_lvl,
  output logic             rd_valid,
  output logic [1:0]       rd_et,
  output logic [2:0]       rd_acc,
  output logic             rd_su,
  output logic             rd_mod,
  output logic             rd_ref,
  output logic [1:0]       rd_lvl,
  output logic [TAG_W-1:0] rd_vtag,
  output logic [CTX_W-1:0] rd_ctx,
  output logic [PPN_W-1:0] rd_ppn,
  output logic             rd_cach
);
  import tlbe_pkg::*;

  localparam int S2 = OFF_W + I3_W;
  localparam int S1 = OFF_W + I3_W + I2_W;

  logic [I1_W-1:0] q_i1;
  logic [I2_W-1:0] q_i2;
  logic [I3_W-1:0] q_i3;
  logic            clr_en;
  logic            unused_ld;

  assign unused_ld = ^ld_va[OFF_W-1:0];
  assign clr_en    = inv_en | (fp_hit & fp_flush);

  tlbe_store #(.CTX_W(CTX_W), .I1_W(I1_W), .I2_W(I2_W), .I3_W(I3_W), .PPN_W(PPN_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .ld_en(ld_en), .ld_et(ld_et), .ld_acc(ld_acc), .ld_mod(ld_mod), .ld_ref(ld_ref),
    .ld_lvl(ld_lvl), .ld_i1(ld_va[VA_W-1 -: I1_W]), .ld_i2(ld_va[S1-1 -: I2_W]),
    .ld_i3(ld_va[S2-1 -: I3_W]), .ld_ctx(ld_ctx), .ld_ppn(ld_ppn), .ld_cach(ld_cach),
    .clr_en(clr_en), .set_mod_en(set_mod_en),
    .q_valid(rd_valid), .q_et(rd_et), .q_acc(rd_acc), .q_su(rd_su), .q_mod(rd_mod),
    .q_ref(rd_ref), .q_lvl(rd_lvl), .q_i1(q_i1), .q_i2(q_i2), .q_i3(q_i3),
    .q_ctx(rd_ctx), .q_ppn(rd_ppn), .q_cach(rd_cach)
  );

  tlbe_lookup #(.CTX_W(CTX_W), .I1_W(I1_W), .I2_W(I2_W), .I3_W(I3_W), .OFF_W(OFF_W),
                .PPN_W(PPN_W)) u_lookup (
    .va(lk_va), .ctx(lk_ctx), .q_valid(rd_valid), .q_lvl(rd_lvl),
    .q_i1(q_i1), .q_i2(q_i2), .q_i3(q_i3), .q_ctx(rd_ctx), .q_ppn(rd_ppn),
    .hit(lk_hit), .pa(lk_pa)
  );

  tlbe_fpmatch #(.CTX_W(CTX_W), .I1_W(I1_W), .I2_W(I2_W), .I3_W(I3_W),
                 .OFF_W(OFF_W)) u_fp (
    .fp_en(fp_en), .fp_addr(fp_addr), .fp_ctx(fp_ctx), .q_valid(rd_valid),
    .q_lvl(rd_lvl), .q_i1(q_i1), .q_i2(q_i2), .q_i3(q_i3), .q_ctx(rd_ctx),
    .hit(fp_hit)
  );

  assign rd_vtag = {q_i1, q_i2, q_i3};
  assign fp_lvl  = rd_lvl;

  AST_HIT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit || fp_hit) |-> rd_valid); // R3
  AST_HIT_NEEDS_CTX: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (lk_ctx == rd_ctx)); // R3
  AST_OFFSET_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (lk_pa[OFF_W-1:0] == lk_va[OFF_W-1:0])); // R4
  AST_FLUSH_HIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (fp_hit && fp_flush && !ld_en) |=> !rd_valid); // R6
  AST_PROBE_KEEPS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (fp_en && !fp_flush && !inv_en && !ld_en) |=> $stable(rd_valid)); // R6
  AST_RESERVED_TYPE_MISSES: assert property (@(posedge clk) disable iff (!rst_n)
    (fp_addr[FP_TY_LSB+FP_TY_W-1:FP_TY_LSB] > FP_ALL) |-> !fp_hit); // R9
  AST_LOAD_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && clr_en) |=> rd_valid); // R7
endmodule

// File: tb/tlb_tag_entry_test.sv
module tlb_tag_entry_test;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  logic ld_en, ld_mod, ld_ref, ld_cach, inv_en, set_mod_en, fp_en, fp_flush;
  logic [1:0] ld_et, ld_lvl;
  logic [2:0] ld_acc;
  logic [31:0] ld_va, lk_va, fp_addr;
  logic [7:0] ld_ctx, lk_ctx, fp_ctx;
  logic [23:0] ld_ppn;
  logic lk_hit, fp_hit, rd_valid, rd_su, rd_mod, rd_ref, rd_cach;
  logic [35:0] lk_pa;
  logic [1:0] fp_lvl, rd_et, rd_lvl;
  logic [2:0] rd_acc;
  logic [19:0] rd_vtag;
  logic [7:0] rd_ctx;
  logic [23:0] rd_ppn;

  tlb_tag_entry uut (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_et(ld_et), .ld_acc(ld_acc),
    .ld_mod(ld_mod), .ld_ref(ld_ref), .ld_lvl(ld_lvl), .ld_va(ld_va), .ld_ctx(ld_ctx),
    .ld_ppn(ld_ppn), .ld_cach(ld_cach), .inv_en(inv_en), .set_mod_en(set_mod_en),
    .lk_va(lk_va), .lk_ctx(lk_ctx), .lk_hit(lk_hit), .lk_pa(lk_pa),
    .fp_en(fp_en), .fp_flush(fp_flush), .fp_addr(fp_addr), .fp_ctx(fp_ctx),
    .fp_hit(fp_hit), .fp_lvl(fp_lvl), .rd_valid(rd_valid), .rd_et(rd_et),
    .rd_acc(rd_acc), .rd_su(rd_su), .rd_mod(rd_mod), .rd_ref(rd_ref), .rd_lvl(rd_lvl),
    .rd_vtag(rd_vtag), .rd_ctx(rd_ctx), .rd_ppn(rd_ppn), .rd_cach(rd_cach)
  );

  int checks = 0;
  int errors = 0;

  // reference model of the stored slot
  logic m_valid, m_su, m_mod, m_ref, m_cach;
  logic [1:0] m_et, m_lvl;
  logic [2:0] m_acc;
  logic [19:0] m_tag;
  logic [7:0] m_ctx;
  logic [23:0] m_ppn;

  task automatic chk(input logic ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic e_lk_hit(input logic [31:0] va, input logic [7:0] c);
    if (!m_valid || c != m_ctx) return 1'b0;
    case (m_lvl)
      2'b00: return va[31:12] == m_tag;
      2'b01: return va[31:18] == m_tag[19:6];
      2'b10: return va[31:24] == m_tag[19:12];
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [35:0] e_pa(input logic [31:0] va);
    case (m_lvl)
      2'b00: return {m_ppn, va[11:0]};
      2'b01: return {m_ppn[23:6], va[17:0]};
      2'b10: return {m_ppn[23:12], va[23:0]};
      default: return {m_ppn[23:20], va};
    endcase
  endfunction

  function automatic logic e_fp_hit(input logic en, input logic [31:0] a,
                                    input logic [7:0] c);
    logic cx;
    cx = (c == m_ctx);
    if (!en || !m_valid) return 1'b0;
    case (a[10:8])
      3'b000: return cx && m_lvl == 2'b00 && a[31:12] == m_tag;
      3'b001: return cx && m_lvl <= 2'b01 && a[31:18] == m_tag[19:6];
      3'b010: return cx && m_lvl != 2'b11 && a[31:24] == m_tag[19:12];
      3'b011: return cx;
      3'b100: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic idle();
    ld_en = 0; inv_en = 0; set_mod_en = 0; fp_en = 0; fp_flush = 0;
  endtask

  // one clock: check combinational replies, advance model, check stored fields
  task automatic go();
    logic eh, efh;
    logic n_valid, n_mod;
    @(negedge clk);
    #1;
    eh  = e_lk_hit(lk_va, lk_ctx);
    efh = e_fp_hit(fp_en, fp_addr, fp_ctx);
    chk(lk_hit === eh, "R3 lookup hit", 64'(lk_hit), 64'(eh));
    if (eh) chk(lk_pa === e_pa(lk_va), "R4 merged address", 64'(lk_pa), 64'(e_pa(lk_va)));
    if (fp_addr[10:8] > 3'd4)
      chk(fp_hit === 1'b0, "R9 reserved type", 64'(fp_hit), 64'd0);
    else
      chk(fp_hit === efh, "R5 flush/probe hit", 64'(fp_hit), 64'(efh));
    if (efh) chk(fp_lvl === m_lvl, "R6 probe level", 64'(fp_lvl), 64'(m_lvl));
    n_valid = m_valid;
    n_mod = m_mod;
    if (!ld_en) begin
      if (inv_en || (efh && fp_flush)) n_valid = 1'b0;
      if (set_mod_en && m_valid) n_mod = 1'b1;
    end
    @(posedge clk);
    #1;
    if (ld_en) begin
      m_valid = 1; m_et = ld_et; m_acc = ld_acc; m_su = (ld_acc >= 3'd6);
      m_mod = ld_mod; m_ref = ld_ref; m_lvl = ld_lvl; m_tag = ld_va[31:12];
      m_ctx = ld_ctx; m_ppn = ld_ppn; m_cach = ld_cach;
    end else begin
      m_valid = n_valid;
      m_mod = n_mod;
    end
    chk(rd_valid === m_valid, "R6/R7 valid", 64'(rd_valid), 64'(m_valid));
    chk(rd_mod === m_mod, "R8 modified", 64'(rd_mod), 64'(m_mod));
    chk(rd_su === m_su, "R2 supervisor flag", 64'(rd_su), 64'(m_su));
    chk({rd_et, rd_acc, rd_ref, rd_lvl, rd_vtag, rd_ctx, rd_ppn, rd_cach} ===
        {m_et, m_acc, m_ref, m_lvl, m_tag, m_ctx, m_ppn, m_cach}, "R2 stored fields",
        64'({rd_et, rd_acc, rd_ref, rd_lvl, rd_vtag, rd_ctx, rd_ppn, rd_cach}),
        64'({m_et, m_acc, m_ref, m_lvl, m_tag, m_ctx, m_ppn, m_cach}));
  endtask

  task automatic load(input logic [1:0] lv, input logic [2:0] acc, input logic [31:0] va,
                      input logic [7:0] c, input logic [23:0] p);
    idle();
    ld_en = 1; ld_et = 2'b10; ld_acc = acc; ld_mod = 0; ld_ref = 1; ld_lvl = lv;
    ld_va = va; ld_ctx = c; ld_ppn = p; ld_cach = 1;
    go();
    ld_en = 0;
  endtask

  function automatic logic [31:0] near_tag(input int fld);
    logic [31:0] v;
    v = {m_tag, 12'(($urandom))};
    case (fld)
      1: v[31:24] = ~v[31:24];
      2: v[23:18] = ~v[23:18];
      3: v[17:12] = ~v[17:12];
      default: ;
    endcase
    return v;
  endfunction

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired checks=%0d", checks);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5A17));
    idle();
    ld_et = 0; ld_acc = 0; ld_mod = 0; ld_ref = 0; ld_lvl = 0; ld_va = 0; ld_ctx = 0;
    ld_ppn = 0; ld_cach = 0; lk_va = 0; lk_ctx = 0; fp_addr = 32'h0000_0400; fp_ctx = 0;
    fp_en = 1;
    m_valid = 0; m_et = 0; m_acc = 0; m_su = 0; m_mod = 0; m_ref = 0; m_lvl = 0;
    m_tag = 0; m_ctx = 0; m_ppn = 0; m_cach = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1: cleared slot, zero tag and context must still not hit
    chk(rd_valid === 1'b0, "R1 reset valid", 64'(rd_valid), 64'd0);
    chk(lk_hit === 1'b0, "R1 reset lookup", 64'(lk_hit), 64'd0);
    chk(fp_hit === 1'b0, "R1 reset flush-all", 64'(fp_hit), 64'd0);
    chk({rd_ppn, rd_vtag, rd_ctx, rd_mod, rd_su} === '0, "R1 reset fields",
        64'({rd_ppn, rd_vtag, rd_ctx}), 64'd0);
    rst_n = 1;
    go();

    // every level against single-field mismatches, lookup and probe of every type
    for (int lv = 0; lv < 4; lv++) begin
      load(2'(lv), 3'(5 + lv % 3), 32'hA5F0_3000 ^ (32'(lv) << 20), 8'h3C, 24'hC0FFEE);
      for (int fld = 0; fld < 4; fld++) begin
        for (int ty = 0; ty < 6; ty++) begin
          idle();
          lk_va = near_tag(fld); lk_ctx = m_ctx;
          fp_en = 1; fp_flush = 0;
          fp_addr = near_tag(fld); fp_addr[10:8] = 3'(ty); fp_ctx = m_ctx;
          go();
        end
      end
      idle();
      lk_va = near_tag(0); lk_ctx = m_ctx ^ 8'h01;
      fp_en = 1; fp_addr = near_tag(0); fp_addr[10:8] = 3'b011; fp_ctx = m_ctx ^ 8'h80;
      go();
    end
    // R6 flush of everything clears the slot
    idle(); fp_en = 1; fp_flush = 1; fp_addr = 32'h0000_0400; go();
    // R8 set-modified on an invalid slot does nothing
    idle(); set_mod_en = 1; go();
    // R7 load wins over invalidate and flush in the same cycle
    load(2'b00, 3'd7, 32'h1234_5000, 8'h11, 24'h000ABC);
    idle(); ld_en = 1; inv_en = 1; fp_en = 1; fp_flush = 1; fp_addr = 32'h0000_0400;
    ld_va = 32'h7654_3000; ld_mod = 0; go();
    idle(); set_mod_en = 1; go();
    idle(); inv_en = 1; go();

    // random traffic close to the stored tag
    for (int n = 0; n < 4000; n++) begin
      idle();
      ld_en = ($urandom % 6) == 0;
      ld_et = 2'($urandom); ld_acc = 3'($urandom); ld_mod = 1'($urandom);
      ld_ref = 1'($urandom); ld_lvl = 2'($urandom); ld_va = $urandom;
      ld_ctx = ($urandom % 2) ? m_ctx : 8'($urandom);
      ld_ppn = 24'($urandom); ld_cach = 1'($urandom);
      inv_en = ($urandom % 15) == 0;
      set_mod_en = ($urandom % 5) == 0;
      lk_va = near_tag(int'($urandom % 5));
      lk_ctx = ($urandom % 5 != 0) ? m_ctx : 8'($urandom);
      fp_en = ($urandom % 3) == 0;
      fp_flush = ($urandom % 4) == 0;
      fp_addr = near_tag(int'($urandom % 5));
      fp_addr[11] = 1'($urandom);
      fp_addr[7:0] = 8'($urandom);
      begin
        int r;
        r = int'($urandom % 10);
        fp_addr[10:8] = (r < 8) ? 3'(r % 5) : 3'(5 + r % 3);
      end
      fp_ctx = ($urandom % 5 != 0) ? m_ctx : 8'($urandom);
      go();
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule